// File: doc/BRIEF.md
# Sender-side visited-bit edge filter

This block sits between the edge generator and the network port of one node in a distributed breadth-first search. Every frontier edge that enters carries a destination vertex and a small tag. The block keeps one bit per vertex in a bitmap stored as 32-bit words. When an edge arrives, the word that holds its destination bit is read and the bit is tested. If the bit is already set, the edge is dropped. If it is clear, the edge is offered downstream and the bit is then set. Many edges that point at the same vertex therefore collapse into the one edge that gets through first.

A second input marks vertices that peers have announced as newly reached in their next-queue updates. Marking these bits ahead of time suppresses edges that would only re-discover them. Edges and marks use valid/ready handshakes. A clear input wipes the bitmap one word per cycle at the start of a new search, and the block reports busy while it does this. Two counters report how many edges were forwarded and how many were dropped.

The control state machine has two states. ST_WIPE clears the word under the wipe pointer and moves to ST_RUN after the last word. It is the state after reset. ST_RUN filters edges and accepts marks, and moves back to ST_WIPE when clear is asserted.

Top module: `vbf_edge_filter`

## Requirements
- R1: An edge whose destination bit is already set is never presented on the output; it is counted as dropped one cycle after it is accepted.
- R2: Forwarding an edge sets its destination bit, so any later edge to that vertex is dropped.
- R3: A vertex accepted on the mark port has its bit set, and edges to it that are accepted afterwards are dropped.
- R4: Vertex v lives in word (v mod NUM_VERTS) / 32 at bit (v mod 32); destination bits at or above log2(NUM_VERTS) are ignored for the lookup.
- R5: A forwarded edge keeps its 32-bit destination field and 16-bit tag field unchanged.
- R6: An accepted edge is offered or dropped in the next cycle, and the bitmap read includes every bit set in the acceptance cycle. As a result, back-to-back edges to the same vertex (or word) need no stall: the second is dropped, and input ready stays high while the output is ready.
- R7: After reset or a clear pulse in ST_RUN, busy is high and both input readies are low for NUM_VERTS/32 cycles. During that time the counters read zero and every bit ends clear.
- R8: A mark and a forwarded edge that set bits in the same word in the same cycle both take effect.
- R9: While an offered edge is not taken, output valid stays high with stable fields and input ready stays low.
- R10: Each counter rises by exactly one per forwarded or dropped edge.
- R11: A mark in the same cycle as an edge acceptance suppresses that edge. A mark that arrives after acceptance does not withdraw an edge already offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts a wipe |
| clear_i | input | 1 | Start a new search: wipe bitmap and counters |
| busy_o | output | 1 | Wipe in progress |
| edge_in_valid_i | input | 1 | Incoming edge valid |
| edge_in_ready_o | output | 1 | Incoming edge accepted |
| edge_in_dst_i | input | 32 | Destination vertex of incoming edge |
| edge_in_tag_i | input | 16 | Tag field of incoming edge |
| edge_out_valid_o | output | 1 | Forwarded edge valid |
| edge_out_ready_i | input | 1 | Downstream ready |
| edge_out_dst_o | output | 32 | Destination of forwarded edge |
| edge_out_tag_o | output | 16 | Tag of forwarded edge |
| mark_valid_i | input | 1 | Peer-announced vertex valid |
| mark_ready_o | output | 1 | Peer vertex accepted |
| mark_vertex_i | input | 32 | Peer-announced vertex |
| fwd_count_o | output | CNT_W | Forwarded edge count |
| drop_count_o | output | CNT_W | Dropped edge count |

## Verification
The hardest cases to reach from the ports are those where two bit updates land in one word in the same cycle. One is a forwarded edge completing while a mark hits a neighbouring bit. The other is a new edge being captured in the same cycle as either of those updates. Directed sequences place edges and marks on vertices inside one 32-vertex word, with exact cycle spacing, to create these collisions. A long random phase then confines vertices to a few words, toggles downstream ready and interleaves marks, so such collisions recur under backpressure.

// File: rtl/vbf_pkg.sv
package vbf_pkg;
    localparam int WORD_BITS = 32;
    localparam int BIT_W     = 5;

    typedef enum logic [0:0] {
        ST_WIPE = 1'b0,
        ST_RUN  = 1'b1
    } vbf_state_e;
endpackage

// File: rtl/vbf_bitmap.sv
module vbf_bitmap #(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    input  logic             set0_en_i,
    input  logic [IDX_W-1:0] set0_idx_i,
    input  logic [31:0]      set0_mask_i,
    input  logic             set1_en_i,
    input  logic [IDX_W-1:0] set1_idx_i,
    input  logic [31:0]      set1_mask_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [31:0]      rd_word_o
);
    logic [31:0] mem [NUM_WORDS];
    logic [31:0] nxt [NUM_WORDS];

    // Per-word next value: both set sources merge into one write per word.
    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            nxt[w] = mem[w];
            if (set0_en_i && set0_idx_i == IDX_W'(w)) nxt[w] = nxt[w] | set0_mask_i;
            if (set1_en_i && set1_idx_i == IDX_W'(w)) nxt[w] = nxt[w] | set1_mask_i;
            if (clr_en_i && clr_idx_i == IDX_W'(w))   nxt[w] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WORDS; w++) mem[w] <= nxt[w];
    end

    // Read returns the post-update word, so same-cycle sets are visible.
    assign rd_word_o = nxt[rd_idx_i];

    AST_EDGE_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set0_en_i && !clr_en_i) |=> ((mem[$past(set0_idx_i)] & $past(set0_mask_i)) != 0)); // R2

    AST_MARK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set1_en_i && !clr_en_i) |=> ((mem[$past(set1_idx_i)] & $past(set1_mask_i)) != 0)); // R3

    AST_MERGED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (set0_en_i && set1_en_i && set0_idx_i == set1_idx_i && !clr_en_i)
        |=> ((mem[$past(set0_idx_i)] & ($past(set0_mask_i) | $past(set1_mask_i)))
             == ($past(set0_mask_i) | $past(set1_mask_i)))); // R8
endmodule

// File: rtl/vbf_ctrl.sv
module vbf_ctrl
    import vbf_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic             busy_o,
    output logic             run_o,
    output logic             flush_o,
    output logic             wipe_en_o,
    output logic [IDX_W-1:0] wipe_idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    vbf_state_e       state_q;
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WIPE;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_WIPE: begin
                    if (ptr_q == LAST_IDX) begin
                        state_q <= ST_RUN;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (clear_i) begin
                        state_q <= ST_WIPE;
                        ptr_q   <= '0;
                    end
                end
                default: state_q <= ST_WIPE;
            endcase
        end
    end

    always_comb begin
        busy_o     = 1'b0;
        run_o      = 1'b0;
        flush_o    = 1'b0;
        wipe_en_o  = 1'b0;
        wipe_idx_o = ptr_q;
        unique case (state_q)
            ST_WIPE: begin
                busy_o    = 1'b1;
                wipe_en_o = 1'b1;
            end
            ST_RUN: begin
                run_o   = 1'b1;
                flush_o = clear_i;
            end
            default: busy_o = 1'b1;
        endcase
    end

    AST_WIPE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIPE && ptr_q == LAST_IDX) |=> (state_q == ST_RUN)); // R7
endmodule

// File: rtl/vbf_stage.sv
module vbf_stage
    import vbf_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             flush_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [31:0]      in_dst_i,
    input  logic [15:0]      in_tag_i,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [31:0]      rd_word_i,
    output logic             set_en_o,
    output logic [IDX_W-1:0] set_idx_o,
    output logic [31:0]      set_mask_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [31:0]      out_dst_o,
    output logic [15:0]      out_tag_o,
    output logic [CNT_W-1:0] fwd_cnt_o,
    output logic [CNT_W-1:0] drop_cnt_o
);
    logic        p_vld_q, p_hit_q;
    logic [31:0] p_dst_q;
    logic [15:0] p_tag_q;
    logic        done, fwd_fire, drop_fire, take, active;

    assign active    = run_i && !flush_i;
    assign fwd_fire  = p_vld_q && !p_hit_q && out_ready_i;
    assign drop_fire = p_vld_q && p_hit_q;
    assign done      = fwd_fire || drop_fire;
    assign in_ready_o = active && (!p_vld_q || done);
    assign take      = in_valid_i && in_ready_o;

    assign rd_idx_o   = in_dst_i[BIT_W +: IDX_W];
    assign set_en_o   = fwd_fire && active;
    assign set_idx_o  = p_dst_q[BIT_W +: IDX_W];
    assign set_mask_o = 32'(1) << p_dst_q[BIT_W-1:0];

    assign out_valid_o = p_vld_q && !p_hit_q;
    assign out_dst_o   = p_dst_q;
    assign out_tag_o   = p_tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_vld_q    <= 1'b0;
            p_hit_q    <= 1'b0;
            p_dst_q    <= '0;
            p_tag_q    <= '0;
            fwd_cnt_o  <= '0;
            drop_cnt_o <= '0;
        end else if (!active) begin
            p_vld_q    <= 1'b0;
            fwd_cnt_o  <= '0;
            drop_cnt_o <= '0;
        end else begin
            if (take) begin
                p_vld_q <= 1'b1;
                p_hit_q <= rd_word_i[in_dst_i[BIT_W-1:0]];
                p_dst_q <= in_dst_i;
                p_tag_q <= in_tag_i;
            end else if (done) begin
                p_vld_q <= 1'b0;
            end
            if (fwd_fire)  fwd_cnt_o  <= fwd_cnt_o + 1'b1;
            if (drop_fire) drop_cnt_o <= drop_cnt_o + 1'b1;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && active) |=> (out_valid_o && $stable(out_dst_o) && $stable(out_tag_o))); // R9

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (fwd_cnt_o == $past(fwd_cnt_o) || fwd_cnt_o == $past(fwd_cnt_o) + 1'b1)); // R10

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (drop_cnt_o == $past(drop_cnt_o) || drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R10
endmodule

// File: rtl/vbf_edge_filter.sv
module vbf_edge_filter
    import vbf_pkg::*;
#(
    parameter int NUM_VERTS = 1024,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic             busy_o,
    input  logic             edge_in_valid_i,
    output logic             edge_in_ready_o,
    input  logic [31:0]      edge_in_dst_i,
    input  logic [15:0]      edge_in_tag_i,
    output logic             edge_out_valid_o,
    input  logic             edge_out_ready_i,
    output logic [31:0]      edge_out_dst_o,
    output logic [15:0]      edge_out_tag_o,
    input  logic             mark_valid_i,
    output logic             mark_ready_o,
    input  logic [31:0]      mark_vertex_i,
    output logic [CNT_W-1:0] fwd_count_o,
    output logic [CNT_W-1:0] drop_count_o
);
    localparam int NUM_WORDS = NUM_VERTS / WORD_BITS;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    logic             run, flush, wipe_en;
    logic [IDX_W-1:0] wipe_idx, rd_idx, set_idx;
    logic [31:0]      rd_word, set_mask, mark_mask;
    logic             set_en, mark_en;

    assign mark_ready_o = run && !flush;
    assign mark_en      = mark_valid_i && mark_ready_o;
    assign mark_mask    = 32'(1) << mark_vertex_i[BIT_W-1:0];

    vbf_ctrl #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .busy_o     (busy_o),
        .run_o      (run),
        .flush_o    (flush),
        .wipe_en_o  (wipe_en),
        .wipe_idx_o (wipe_idx)
    );

    vbf_bitmap #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) bitmap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_en_i    (wipe_en),
        .clr_idx_i   (wipe_idx),
        .set0_en_i   (set_en),
        .set0_idx_i  (set_idx),
        .set0_mask_i (set_mask),
        .set1_en_i   (mark_en),
        .set1_idx_i  (mark_vertex_i[BIT_W +: IDX_W]),
        .set1_mask_i (mark_mask),
        .rd_idx_i    (rd_idx),
        .rd_word_o   (rd_word)
    );

    vbf_stage #(.IDX_W(IDX_W), .CNT_W(CNT_W)) stage_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .flush_i     (flush),
        .in_valid_i  (edge_in_valid_i),
        .in_ready_o  (edge_in_ready_o),
        .in_dst_i    (edge_in_dst_i),
        .in_tag_i    (edge_in_tag_i),
        .rd_idx_o    (rd_idx),
        .rd_word_i   (rd_word),
        .set_en_o    (set_en),
        .set_idx_o   (set_idx),
        .set_mask_o  (set_mask),
        .out_valid_o (edge_out_valid_o),
        .out_ready_i (edge_out_ready_i),
        .out_dst_o   (edge_out_dst_o),
        .out_tag_o   (edge_out_tag_o),
        .fwd_cnt_o   (fwd_count_o),
        .drop_cnt_o  (drop_count_o)
    );

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!edge_in_ready_o && !mark_ready_o && !edge_out_valid_o)); // R7
endmodule

// File: tb/vbf_edge_filter_tb.sv
module vbf_edge_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 1024;
    localparam int NW = NV / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        busy_o;
    logic        ev = 1'b0;
    logic        erdy;
    logic [31:0] edst = '0;
    logic [15:0] etag = '0;
    logic        ovld;
    logic        ordy = 1'b1;
    logic [31:0] odst;
    logic [15:0] otag;
    logic        mv = 1'b0;
    logic        mrdy;
    logic [31:0] mvert = '0;
    logic [31:0] fwdc, dropc;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbf_edge_filter #(.NUM_VERTS(NV), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .busy_o(busy_o),
        .edge_in_valid_i(ev), .edge_in_ready_o(erdy),
        .edge_in_dst_i(edst), .edge_in_tag_i(etag),
        .edge_out_valid_o(ovld), .edge_out_ready_i(ordy),
        .edge_out_dst_o(odst), .edge_out_tag_o(otag),
        .mark_valid_i(mv), .mark_ready_o(mrdy), .mark_vertex_i(mvert),
        .fwd_count_o(fwdc), .drop_count_o(dropc)
    );

    int errors = 0;
    int checks = 0;

    // Behavioural reference state
    bit          vis [NV];
    bit          m_run = 0, m_pv = 0, m_ph = 0;
    int          m_ptr = 0;
    logic [31:0] m_pd = '0;
    logic [15:0] m_pt = '0;
    int          m_fwd = 0, m_drop = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        bit exp_erdy, exp_ovld;
        exp_erdy = m_run && !clear_i && (!m_pv || m_ph || ordy);
        exp_ovld = m_pv && !m_ph;
        chk("R7", "busy", busy_o, !m_run);
        chk("R6", "edge_in_ready", erdy, exp_erdy);
        chk("R7", "mark_ready", mrdy, m_run && !clear_i);
        chk("R1", "edge_out_valid", ovld, exp_ovld);
        if (exp_ovld) begin
            chk("R5", "dst", odst, m_pd);
            chk("R5", "tag", otag, m_pt);
        end
        chk("R10", "fwd_count", fwdc, m_fwd);
        chk("R10", "drop_count", dropc, m_drop);
    endtask

    task automatic model_step();
        bit done, fwd, acc;
        if (!rst_n) begin
            m_run = 0; m_ptr = 0; m_pv = 0; m_fwd = 0; m_drop = 0;
        end else if (!m_run) begin
            for (int b = 0; b < 32; b++) vis[m_ptr*32 + b] = 0;
            m_fwd = 0; m_drop = 0;
            if (m_ptr == NW - 1) begin m_run = 1; m_ptr = 0; end
            else m_ptr++;
        end else if (clear_i) begin
            m_run = 0; m_ptr = 0; m_pv = 0; m_fwd = 0; m_drop = 0;
        end else begin
            fwd  = m_pv && !m_ph && ordy;
            done = fwd || (m_pv && m_ph);
            acc  = ev && (!m_pv || done);
            if (mv) vis[mvert % NV] = 1;
            if (fwd) begin vis[m_pd % NV] = 1; m_fwd++; end
            if (m_pv && m_ph) m_drop++;
            if (acc) begin
                m_pv = 1; m_ph = vis[edst % NV]; m_pd = edst; m_pt = etag;
            end else if (done) m_pv = 0;
        end
    endtask

    task automatic cyc(bit v, int d, bit r, bit m, int mvx, bit c);
        ev = v; edst = 32'(d); etag = 16'(d) ^ 16'h5A3C; ordy = r;
        mv = m; mvert = 32'(mvx); clear_i = c;
        #1;
        compare_outputs();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        rst_n = 0;
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R7", "reset busy", busy_o, 1);
        chk("R7", "reset fwd count", fwdc, 0);
        rst_n = 1;
        idle(NW + 2);
        chk("R7", "busy after wipe", busy_o, 0);

        // Back-to-back same vertex: second dropped without stall
        cyc(1, 5, 1, 0, 0, 0);
        chk("R6", "ready back-to-back", erdy, 1);
        cyc(1, 5, 1, 0, 0, 0);
        idle(2);
        chk("R2", "fwd after duplicate", fwdc, 1);
        chk("R1", "drop after duplicate", dropc, 1);

        // Aliased index and a different word
        cyc(1, 5 + NV, 1, 0, 0, 0);
        cyc(1, 37, 1, 0, 0, 0);
        idle(2);
        chk("R4", "aliased vertex dropped", dropc, 2);
        chk("R4", "word1 vertex forwarded", fwdc, 2);

        // Mark before edge, and mark in the same cycle as capture
        cyc(0, 0, 1, 1, 200, 0);
        cyc(1, 200, 1, 0, 0, 0);
        idle(2);
        chk("R3", "marked vertex dropped", dropc, 3);
        cyc(1, 210, 1, 1, 210, 0);
        idle(2);
        chk("R11", "same-cycle mark drops", dropc, 4);

        // Forward and mark hitting one word in one cycle
        cyc(1, 301, 1, 0, 0, 0);
        cyc(0, 0, 1, 1, 302, 0);
        cyc(1, 301, 1, 0, 0, 0);
        cyc(1, 302, 1, 0, 0, 0);
        idle(2);
        chk("R8", "merged word fwd", fwdc, 3);
        chk("R8", "merged word drops", dropc, 6);

        // Backpressure with a late mark
        cyc(1, 400, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 400, 0);
        chk("R9", "valid held", ovld, 1);
        chk("R9", "ready low while held", erdy, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R11", "late mark keeps offer", ovld, 1);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 400, 1, 0, 0, 0);
        idle(2);
        chk("R9", "held edge forwarded", fwdc, 4);
        chk("R2", "repeat dropped", dropc, 7);

        // Clear starts a new search
        cyc(0, 0, 1, 0, 0, 1);
        chk("R7", "busy after clear", busy_o, 1);
        chk("R7", "count zero after clear", fwdc, 0);
        idle(NW + 1);
        cyc(1, 5, 1, 0, 0, 0);
        idle(2);
        chk("R7", "bit cleared by wipe", fwdc, 1);

        // Random phase on a few words
        for (int i = 0; i < 3000; i++) begin
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 127) + (($urandom_range(0, 7) == 0) ? NV : 0),
                $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
                $urandom_range(0, 127), (i == 1500));
        end
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule